// File: doc/BRIEF.md
# Multi-Rail Power Sequencer Controller

This block switches four supply rails that feed a downstream FPGA. A host reaches it through a small byte-wide register port. Writing a one to the enable bit starts a ramp. The rails come up one at a time, lowest index first, and each rail waits until the rail before it reports power-good. Every step of the ramp has its own timeout. If a step times out, or if a filtered alarm input asserts while any rail is on, the block drops all rails at once. It records the cause in a fail register and clears the enable bit.

After the rails go off for any reason, the block keeps them off for a fixed discharge interval. A quick off/on sequence therefore cannot leave the sequencer waiting for good signals that never arrive. An enable written during that interval is kept and takes effect as soon as the interval ends.

The status register shows the four raw power-good inputs and the combined filtered alarm. Overall power counts as good only when all four rails are good and no alarm is present. Each alarm input passes through a glitch filter, which changes its output only after a run of identical samples.

Top module: `psq_ctrl`

## Requirements
- R1: After reset, all rail enables are low, `pwr_good_o` is low, and the control, fail and status registers read 0x00.
- R2: Address 0x2000 always reads the version value 0x03, and writes to it have no effect.
- R3: A write to address 0x2006 sets the enable from data bit 0 and ignores bits 7..1. Reading 0x2006 returns the enable in bit 0 with zeros above it.
- R4: Rail k (k > 0) turns on only in a cycle that follows one in which rail k-1 reported good. The rails turn on in index order 0, 1, 2, 3.
- R5: Address 0x200A reads the power-good inputs in bits 3..0 and the filtered alarm (OR of all alarm channels) in bit 4. `pwr_good_o` is high exactly when this byte equals 0x0F.
- R6: If the rail being ramped is not good within STEP_CYC cycles, all rails turn off, the enable clears, and address 0x200B latches a one-hot code with bit k set for failing rail k.
- R7: A filtered alarm while any rail is enabled turns all rails off, clears the enable, and latches fail code 0x10. An alarm while all rails are off causes no fault.
- R8: Writing a one to the enable clears the fail register.
- R9: After the rails turn off, they stay off for DISCH_CYC cycles. An enable written during that time is held and starts a new ramp when the interval ends.
- R10: A filtered alarm changes state only after FILT_LEN consecutive samples at the new level. A shorter pulse has no effect.
- R11: Clearing the enable turns all rails off on the next sequencer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Register byte address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| rail_good_i | input | 4 | Per-rail power-good inputs |
| alarm_i | input | 2 | Raw alarm inputs (overcurrent, overtemperature) |
| rail_en_o | output | 4 | Per-rail supply enables |
| pwr_good_o | output | 1 | All rails good and no alarm |

## Verification
The bench builds the block with STEP_CYC = 20, DISCH_CYC = 40 and FILT_LEN = 4. With these values a step timeout, the full discharge hold and both sides of the alarm filter threshold each fit in a few dozen cycles. A behavioural rail model raises each good input after a delay that the bench can set per rail. Setting one delay to "never" forces the timeout path. Pulses of three and of several cycles on the alarm inputs fall on either side of the filter length.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned ADR_W = 16;

  localparam logic [ADR_W-1:0] A_VER  = 16'h2000;
  localparam logic [ADR_W-1:0] A_CTRL = 16'h2006;
  localparam logic [ADR_W-1:0] A_STAT = 16'h200A;
  localparam logic [ADR_W-1:0] A_FAIL = 16'h200B;

  localparam int unsigned ALARM_BIT = 4;
  localparam int unsigned CODE_W    = 5;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_RAMP,
    ST_ON,
    ST_DISCH
  } seq_st_e;
endpackage

// File: rtl/psq_glitch_filter.sv
module psq_glitch_filter #(
  parameter int unsigned FILT_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_q  <= '0;
      filt_q <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R10: output only moves toward the level just sampled
  p_filt_agree_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(raw_i) == filt_q));
endmodule

// File: rtl/psq_seq_fsm.sv
module psq_seq_fsm
  import psq_pkg::*;
#(
  parameter int unsigned N_RAILS   = 4,
  parameter int unsigned STEP_CYC  = 100,
  parameter int unsigned DISCH_CYC = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               alarm_i,
  input  logic [N_RAILS-1:0] rail_good_i,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               fault_o,
  output logic [CODE_W-1:0]  fault_code_o
);
  localparam int unsigned IW    = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam int unsigned T_MAX = (STEP_CYC > DISCH_CYC) ? STEP_CYC : DISCH_CYC;
  localparam int unsigned TW    = $clog2(T_MAX + 1);

  seq_st_e           state_q;
  logic [IW-1:0]     idx_q;
  logic [TW-1:0]     tmr_q;
  logic [N_RAILS-1:0] rail_en_q;

  logic active, step_good, step_to, last_step;

  assign active    = (state_q == ST_RAMP) || (state_q == ST_ON);
  assign step_good = rail_good_i[idx_q];
  assign step_to   = (state_q == ST_RAMP) && !step_good && (tmr_q == TW'(STEP_CYC - 1));
  assign last_step = (idx_q == IW'(N_RAILS - 1));

  always_comb begin
    fault_o      = active && (alarm_i || step_to);
    fault_code_o = '0;
    if (alarm_i)      fault_code_o[ALARM_BIT] = 1'b1;
    else if (step_to) fault_code_o = CODE_W'(1) << idx_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      idx_q     <= '0;
      tmr_q     <= '0;
      rail_en_q <= '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (en_i) begin
            state_q   <= ST_RAMP;
            idx_q     <= '0;
            tmr_q     <= '0;
            rail_en_q <= N_RAILS'(1);
          end
        end
        ST_RAMP, ST_ON: begin
          if (fault_o || !en_i) begin
            state_q   <= ST_DISCH;
            tmr_q     <= '0;
            rail_en_q <= '0;
          end else if (state_q == ST_RAMP) begin
            if (step_good) begin
              tmr_q <= '0;
              if (last_step) begin
                state_q <= ST_ON;
              end else begin
                idx_q     <= idx_q + 1'b1;
                rail_en_q <= {rail_en_q[N_RAILS-2:0], 1'b1};
              end
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        ST_DISCH: begin
          if (tmr_q == TW'(DISCH_CYC - 1)) begin
            state_q <= ST_OFF;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign rail_en_o = rail_en_q;

  for (genvar k = 1; k < N_RAILS; k++) begin : g_order
    p_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_en_q[k]) |-> $past(rail_good_i[k-1]));
  end

  p_fault_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (rail_en_q == '0));

  p_disch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DISCH) |-> (rail_en_q == '0));

  p_disable_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !en_i) |=> (rail_en_q == '0));
endmodule

// File: rtl/psq_regs.sv
module psq_regs
  import psq_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  parameter logic [7:0]  VERSION = 8'h03
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADR_W-1:0]   addr_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [N_RAILS-1:0] rail_good_i,
  input  logic               alarm_i,
  input  logic               fault_i,
  input  logic [CODE_W-1:0]  fault_code_i,
  output logic               en_o,
  output logic               pwr_good_o
);
  logic              en_q;
  logic [CODE_W-1:0] fail_q;
  logic [REG_W-1:0]  status;
  logic              ctrl_wr;
  logic              unused_wdata;

  assign ctrl_wr      = wr_en_i && (addr_i == A_CTRL);
  assign unused_wdata = ^wdata_i[REG_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fail_q <= '0;
    end else if (fault_i) begin
      en_q   <= 1'b0;
      fail_q <= fault_code_i;
    end else if (ctrl_wr) begin
      en_q <= wdata_i[0];
      if (wdata_i[0]) fail_q <= '0;
    end
  end

  always_comb begin
    status                     = '0;
    status[N_RAILS-1:0]        = rail_good_i;
    status[ALARM_BIT]          = alarm_i;
  end

  always_comb begin
    unique case (addr_i)
      A_VER:   rdata_o = VERSION;
      A_CTRL:  rdata_o = {{(REG_W-1){1'b0}}, en_q};
      A_STAT:  rdata_o = status;
      A_FAIL:  rdata_o = {{(REG_W-CODE_W){1'b0}}, fail_q};
      default: rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign pwr_good_o = (status == REG_W'({N_RAILS{1'b1}}));

  p_ctrl_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !fault_i) |=> (en_q == $past(wdata_i[0])));

  p_fail_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[0] && !fault_i) |=> (fail_q == '0));

  p_fault_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !en_q);
endmodule

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned N_RAILS   = 4,
  parameter int unsigned N_ALARMS  = 2,
  parameter int unsigned STEP_CYC  = 100_000_000,
  parameter int unsigned DISCH_CYC = 50_000_000,
  parameter int unsigned FILT_LEN  = 16,
  parameter logic [7:0]  VERSION   = 8'h03
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         addr_i,
  input  logic                wr_en_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [N_RAILS-1:0]  rail_good_i,
  input  logic [N_ALARMS-1:0] alarm_i,
  output logic [N_RAILS-1:0]  rail_en_o,
  output logic                pwr_good_o
);
  logic [N_ALARMS-1:0] alarm_filt;
  logic                alarm_any;
  logic                en;
  logic                fault;
  logic [CODE_W-1:0]   fault_code;

  for (genvar a = 0; a < N_ALARMS; a++) begin : g_filt
    psq_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (alarm_i[a]),
      .filt_o (alarm_filt[a])
    );
  end

  assign alarm_any = |alarm_filt;

  psq_seq_fsm #(
    .N_RAILS  (N_RAILS),
    .STEP_CYC (STEP_CYC),
    .DISCH_CYC(DISCH_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .alarm_i     (alarm_any),
    .rail_good_i (rail_good_i),
    .rail_en_o   (rail_en_o),
    .fault_o     (fault),
    .fault_code_o(fault_code)
  );

  psq_regs #(
    .N_RAILS(N_RAILS),
    .VERSION(VERSION)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .rail_good_i (rail_good_i),
    .alarm_i     (alarm_any),
    .fault_i     (fault),
    .fault_code_i(fault_code),
    .en_o        (en),
    .pwr_good_o  (pwr_good_o)
  );
endmodule

// File: tb/psq_ctrl_bench.sv
module psq_ctrl_bench;
  localparam int STEP_CYC  = 20;
  localparam int DISCH_CYC = 40;
  localparam int FILT_LEN  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  rail_good = '0;
  logic [1:0]  alarm = '0;
  logic [3:0]  rail_en;
  logic        pwr_good;

  always #4 clk = ~clk;

  psq_ctrl #(
    .STEP_CYC (STEP_CYC),
    .DISCH_CYC(DISCH_CYC),
    .FILT_LEN (FILT_LEN)
  ) u_psq_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .rail_good_i(rail_good),
    .alarm_i    (alarm),
    .rail_en_o  (rail_en),
    .pwr_good_o (pwr_good)
  );

  // rail model: good rises dly cycles after enable, never when dly >= 200
  int dly [4] = '{2, 3, 5, 4};
  int rcnt[4] = '{0, 0, 0, 0};
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (!rail_en[i]) begin
        rcnt[i]      <= 0;
        rail_good[i] <= 1'b0;
      end else begin
        if (rcnt[i] < 200) rcnt[i] <= rcnt[i] + 1;
        rail_good[i] <= (dly[i] < 200) && (rcnt[i] >= dly[i]);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard for register reads
  typedef struct {
    logic [7:0] exp;
    string      tag;
    int         due;
  } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      chk(it.tag, int'(rdata), int'(it.exp));
    end
  end

  task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    addr = a;
    sb.push_back('{exp: e, tag: tag, due: cyc + 1});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pgood(int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (pwr_good) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  // order monitor for R4
  logic [3:0] prev_en = '0;
  int order_bad = 0;
  int rises = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rail_en[i] && !prev_en[i]) begin
        rises++;
        if (i > 0 && !(prev_en[i-1] && rail_good[i-1])) order_bad++;
      end
    end
    prev_en <= rail_en;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [15:0] A_VER  = 16'h2000;
  localparam logic [15:0] A_CTRL = 16'h2006;
  localparam logic [15:0] A_STAT = 16'h200A;
  localparam logic [15:0] A_FAIL = 16'h200B;

  initial begin
    bit ok;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rail_en", int'(rail_en), 0);
    chk("R1 pwr_good", int'(pwr_good), 0);
    rd(A_CTRL, 8'h00, "R1 ctrl");
    rd(A_FAIL, 8'h00, "R1 fail");
    rd(A_STAT, 8'h00, "R1 status");

    // R2 version constant
    rd(A_VER, 8'h03, "R2 version");
    wr(A_VER, 8'hFF);
    rd(A_VER, 8'h03, "R2 version after write");

    // R3 enable bit, upper bits ignored
    rises = 0;
    wr(A_CTRL, 8'h81);
    rd(A_CTRL, 8'h01, "R3 ctrl readback");
    chk("R5 partial ramp not good", int'(pwr_good), 0);
    wait_pgood(200, ok);
    chk("R4 ramp reaches good", int'(ok), 1);
    chk("R4 order", order_bad, 0);
    chk("R4 four rails rose", rises, 4);
    chk("R4 all enabled", int'(rail_en), 4'hF);
    rd(A_STAT, 8'h0F, "R5 status all good");

    // R10 short alarm pulse ignored
    @(negedge clk);
    alarm[0] = 1'b1;
    repeat (FILT_LEN - 1) @(negedge clk);
    alarm[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 rails stay on", int'(rail_en), 4'hF);
    rd(A_FAIL, 8'h00, "R10 no fail");
    rd(A_STAT, 8'h0F, "R10 no alarm");

    // R7 sustained alarm while on
    alarm[1] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7 rails off", int'(rail_en), 0);
    rd(A_FAIL, 8'h10, "R7 fail code");
    rd(A_CTRL, 8'h00, "R7 enable cleared");
    alarm[1] = 1'b0;
    repeat (10) @(negedge clk);

    // R8 + R9: enable during discharge clears fail, is held
    wr(A_CTRL, 8'h01);
    rd(A_FAIL, 8'h00, "R8 fail cleared");
    chk("R9 held during discharge", int'(rail_en), 0);
    wait_pgood(300, ok);
    chk("R9 held enable later served", int'(ok), 1);

    // R11 + R9 disable then immediate re-enable
    wr(A_CTRL, 8'h00);
    wr(A_CTRL, 8'h01);
    @(negedge clk);
    chk("R11 rails off after disable", int'(rail_en), 0);
    n = 0;
    while (rail_en[0] == 1'b0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk("R9 discharge min", int'(n >= DISCH_CYC - 3), 1);
    chk("R9 discharge max", int'(n <= DISCH_CYC + 3), 1);
    wait_pgood(200, ok);
    chk("R9 ramp after discharge", int'(ok), 1);

    // R6 step timeout on rail 2
    wr(A_CTRL, 8'h00);
    repeat (DISCH_CYC + 20) @(negedge clk);
    dly[2] = 255;
    wr(A_CTRL, 8'h01);
    repeat (100) @(negedge clk);
    chk("R6 rails off", int'(rail_en), 0);
    rd(A_FAIL, 8'h04, "R6 fail code rail2");
    rd(A_CTRL, 8'h00, "R6 enable cleared");

    // R8 next enable clears fail
    dly[2] = 5;
    repeat (DISCH_CYC) @(negedge clk);
    wr(A_CTRL, 8'h01);
    rd(A_FAIL, 8'h00, "R8 fail cleared on enable");
    wait_pgood(200, ok);
    chk("R8 ramp ok", int'(ok), 1);
    wr(A_CTRL, 8'h00);
    repeat (DISCH_CYC + 20) @(negedge clk);

    // R5/R7 alarm while off: shown, no fault
    alarm[0] = 1'b1;
    repeat (8) @(negedge clk);
    rd(A_STAT, 8'h10, "R5 status alarm only");
    rd(A_FAIL, 8'h00, "R7 no fault while off");
    chk("R5 pwr_good low with alarm", int'(pwr_good), 0);
    chk("R7 rails stay off", int'(rail_en), 0);
    alarm[0] = 1'b0;
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule